// File: doc/BRIEF.md
# Receive Capture FIFO with Programmable Level Flags

This block buffers 32-bit words arriving from a parallel capture interface until a bus-side reader drains them. Incoming words are taken only while the receive enable is high. The reader sees the oldest stored word on `rd_data` at all times and removes it by raising `rd_req` for one cycle.

Two threshold levels are loaded together from one configuration word. One marks the FIFO as nearly drained and the other as nearly filled. All four level indications are reported active-high in their negated sense: not-empty, not-almost-empty, not-almost-full and not-full. Two error conditions are recorded and held until software writes ones to clear them. A receive overrun is a word offered while the FIFO is full. A receive underrun is a read request while the FIFO is empty.

A synchronous FIFO clear empties the store without touching the error record. A live word count and the fixed capacity are both available as 20-bit values.

Top module: `rxcap_fifo`

## Requirements
- R1: After reset the word count is 0, both error flags are clear, both thresholds are 32, and the status word is computed from those values by R3, R10 and R11.
- R2: Words leave in the order they were accepted. While the FIFO holds data, `rd_data` shows the oldest word, and a cycle with `rd_req` high removes it.
- R3: `word_count` equals the number of stored words and never exceeds the capacity. Status bit 12 (not-empty) is 1 exactly when the count is non-zero. Status bit 15 (not-full) is 1 exactly when the count is below capacity.
- R4: While `rx_en` is low, offered words are neither stored nor counted as overrun.
- R5: A word offered with `rx_en` high while the FIFO is full and no read happens in that cycle is dropped, and status bit 23 (overrun) is set.
- R6: A read request while the FIFO is empty sets status bit 22 (underrun). `rd_data` is zero whenever the FIFO is empty.
- R7: A cycle with `err_clr_we` high clears each error flag whose bit (23 or 22) is 1 in `err_clr_data`; zero bits leave the flags alone. A new error event in the same cycle wins over its clear.
- R8: A cycle with `fifo_clr` high empties the FIFO and discards any word offered or read in that cycle. The error flags are kept.
- R9: A cycle with `cfg_we` high loads the almost-empty threshold from `cfg_wdata[15:0]` and the almost-full threshold from `cfg_wdata[23:16]`; bits 31:24 are ignored.
- R10: Status bit 13 (not-almost-empty) is 0 exactly when the count is at or below the almost-empty threshold.
- R11: Status bit 14 (not-almost-full) is 0 exactly when the free space (capacity minus count) is at or below the almost-full threshold.
- R12: When the FIFO is full, a cycle that both reads and offers a word pops the oldest word and stores the new one, with no overrun.
- R13: `fifo_size` reads the capacity, 2 to the power `DEPTH_LOG2`. Status bits other than 12 to 15, 22 and 23 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_clr | input | 1 | Synchronous FIFO clear |
| rx_en | input | 1 | Receive enable; gates acceptance of incoming words |
| wr_valid | input | 1 | Incoming word present |
| wr_data | input | 32 | Incoming word |
| rd_req | input | 1 | Read request; pops the oldest word |
| rd_data | output | 32 | Oldest stored word, zero when empty |
| cfg_we | input | 1 | Load the threshold configuration word |
| cfg_wdata | input | 32 | Threshold configuration word |
| err_clr_we | input | 1 | Write-ones-to-clear strobe for the error flags |
| err_clr_data | input | 32 | Clear mask, aligned with the status bit positions |
| status | output | 32 | Level and error status word |
| word_count | output | 20 | Number of stored words |
| fifo_size | output | 20 | Capacity in words |

## Verification
The properties assume that every input is synchronous to `clk` and known (not X) while reset is released. They also assume that `fifo_clr` is sampled like any other control, with no requirement for it to be pulse-shaped. The bench changes all inputs one time unit after a rising edge and holds them until the next edge, so each control is seen exactly once per cycle. The bench uses an 8-word configuration. It sweeps every pair of thresholds from 0 to 9 against every fill level, which covers both flags at and past each boundary, including thresholds larger than the capacity.

// File: rtl/rxcap_fifo_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the receive capture FIFO.
// Assumes a 32-bit status word and a 32-bit configuration word.
package rxcap_fifo_pkg;
    // Status word bit positions that software decodes.
    localparam int ST_NEMPTY = 12;
    localparam int ST_NAE    = 13;
    localparam int ST_NAF    = 14;
    localparam int ST_NFULL  = 15;
    localparam int ST_UNDER  = 22;
    localparam int ST_OVER   = 23;

    // Configuration word fields.
    localparam int CFG_AE_LSB = 0;
    localparam int CFG_AE_W   = 16;
    localparam int CFG_AF_LSB = 16;
    localparam int CFG_AF_W   = 8;

    // Readback width of the count and size values.
    localparam int RDBK_W = 20;

    // Threshold loaded at reset.
    localparam int DEF_THR = 32;

    // Error flag indices inside the sticky error vector.
    localparam int ERR_UNDER = 0;
    localparam int ERR_OVER  = 1;
    localparam int N_ERR     = 2;

    // Negated level indications, all active high.
    typedef struct packed {
        logic nfull;
        logic naf;
        logic nae;
        logic nempty;
    } level_t;
endpackage

// File: rtl/rxcap_fifo_store.sv
`timescale 1ns/1ps
// Data store of the receive FIFO: memory, read/write pointers and word count.
// Assumes push is never raised when full unless pop is also raised,
// and pop is never raised when empty; the top enforces both.
module rxcap_fifo_store #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              push,
    input  logic              pop,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W:0]   count
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int CW    = ADDR_W + 1;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [ADDR_W-1:0] wptr;
    logic [ADDR_W-1:0] rptr;

    // Write the incoming word into the slot at the write pointer.
    always_ff @(posedge clk) begin
        if (push) begin
            mem[wptr] <= wdata;
        end
    end

    // Advance pointers and track the number of stored words.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push) begin
                wptr <= wptr + 1'b1;
            end
            if (pop) begin
                rptr <= rptr + 1'b1;
            end
            case ({push, pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    // Present the oldest word, or zero when nothing is stored.
    always_comb begin
        rdata = (count == '0) ? '0 : mem[rptr];
    end
endmodule

// File: rtl/rxcap_fifo_levels.sv
`timescale 1ns/1ps
// Threshold register and level comparators of the receive FIFO.
// Assumes the count never exceeds the capacity 2**ADDR_W.
module rxcap_fifo_levels
    import rxcap_fifo_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [CFG_AE_W-1:0] cfg_ae,
    input  logic [CFG_AF_W-1:0] cfg_af,
    input  logic [ADDR_W:0]     count,
    output level_t              lvl
);
    localparam int CW    = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

    logic [CFG_AE_W-1:0] ae_thr;
    logic [CFG_AF_W-1:0] af_thr;
    logic [CW-1:0]       free_words;

    // Hold the thresholds loaded from the configuration word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ae_thr <= CFG_AE_W'(DEF_THR);
            af_thr <= CFG_AF_W'(DEF_THR);
        end else if (cfg_we) begin
            ae_thr <= cfg_ae;
            af_thr <= cfg_af;
        end
    end

    // Derive the negated level flags from count and free space.
    always_comb begin
        free_words = DEPTH_C - count;
        lvl.nempty = (count != '0);
        lvl.nfull  = (count != DEPTH_C);
        lvl.nae    = !(32'(count) <= 32'(ae_thr));
        lvl.naf    = !(32'(free_words) <= 32'(af_thr));
    end
endmodule

// File: rtl/rxcap_fifo_errs.sv
`timescale 1ns/1ps
// Sticky error flags with write-ones-to-clear; a set event wins over a clear.
// Assumes event and clear inputs are single-cycle qualified strobes.
module rxcap_fifo_errs #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic         clr_we,
    input  logic [N-1:0] clr_mask,
    output logic [N-1:0] flag
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        // Set on an event, clear on a written one, otherwise hold.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flag[i] <= 1'b0;
            end else if (evt[i]) begin
                flag[i] <= 1'b1;
            end else if (clr_we && clr_mask[i]) begin
                flag[i] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/rxcap_fifo.sv
`timescale 1ns/1ps
// Receive capture FIFO with programmable almost-empty/almost-full levels,
// negated level flags, sticky overrun/underrun and count readback.
// Assumes all inputs are synchronous to clk; reset is synchronous, active low.
module rxcap_fifo
    import rxcap_fifo_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int DEPTH_LOG2 = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_clr,
    input  logic              rx_en,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_req,
    output logic [DATA_W-1:0] rd_data,
    input  logic              cfg_we,
    input  logic [31:0]       cfg_wdata,
    input  logic              err_clr_we,
    input  logic [31:0]       err_clr_data,
    output logic [31:0]       status,
    output logic [RDBK_W-1:0] word_count,
    output logic [RDBK_W-1:0] fifo_size
);
    localparam int DEPTH = 1 << DEPTH_LOG2;
    localparam int CW    = DEPTH_LOG2 + 1;

    logic [CW-1:0]    count;
    logic             empty;
    logic             full;
    logic             offered;
    logic             push;
    logic             pop;
    logic [N_ERR-1:0] err_evt;
    logic [N_ERR-1:0] err_mask;
    logic [N_ERR-1:0] err_flag;
    level_t           lvl;
    logic             unused_cfg_bits;
    logic             unused_clr_bits;

    // Decide which transfers take place this cycle and which errors occur.
    always_comb begin
        empty   = (count == '0);
        full    = (count == CW'(DEPTH));
        offered = wr_valid && rx_en && !fifo_clr;
        pop     = rd_req && !empty && !fifo_clr;
        push    = offered && (!full || pop);
        err_evt = '0;
        err_evt[ERR_OVER]  = offered && full && !pop;
        err_evt[ERR_UNDER] = rd_req && empty && !fifo_clr;
        err_mask = '0;
        err_mask[ERR_OVER]  = err_clr_data[ST_OVER];
        err_mask[ERR_UNDER] = err_clr_data[ST_UNDER];
    end

    rxcap_fifo_store #(
        .DATA_W (DATA_W),
        .ADDR_W (DEPTH_LOG2)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (fifo_clr),
        .push  (push),
        .pop   (pop),
        .wdata (wr_data),
        .rdata (rd_data),
        .count (count)
    );

    rxcap_fifo_levels #(
        .ADDR_W (DEPTH_LOG2)
    ) u_levels (
        .clk    (clk),
        .rst_n  (rst_n),
        .cfg_we (cfg_we),
        .cfg_ae (cfg_wdata[CFG_AE_LSB +: CFG_AE_W]),
        .cfg_af (cfg_wdata[CFG_AF_LSB +: CFG_AF_W]),
        .count  (count),
        .lvl    (lvl)
    );

    rxcap_fifo_errs #(
        .N (N_ERR)
    ) u_errs (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (err_evt),
        .clr_we   (err_clr_we),
        .clr_mask (err_mask),
        .flag     (err_flag)
    );

    // Assemble the status word from level and error flags.
    always_comb begin
        status            = '0;
        status[ST_NEMPTY] = lvl.nempty;
        status[ST_NAE]    = lvl.nae;
        status[ST_NAF]    = lvl.naf;
        status[ST_NFULL]  = lvl.nfull;
        status[ST_UNDER]  = err_flag[ERR_UNDER];
        status[ST_OVER]   = err_flag[ERR_OVER];
    end

    // Widen the count and capacity to the readback width.
    always_comb begin
        word_count = RDBK_W'(count);
        fifo_size  = RDBK_W'(DEPTH);
    end

    assign unused_cfg_bits = ^cfg_wdata[31:CFG_AF_LSB + CFG_AF_W];
    assign unused_clr_bits = ^{err_clr_data[31:ST_OVER + 1],
                               err_clr_data[ST_UNDER - 1:0]};
endmodule

// File: rtl/rxcap_fifo_chk.sv
`timescale 1ns/1ps
// Property checker for rxcap_fifo, attached by bind.
// Assumes inputs are known and synchronous to clk once reset is released.
module rxcap_fifo_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        fifo_clr,
    input logic        rx_en,
    input logic        wr_valid,
    input logic        rd_req,
    input logic        err_clr_we,
    input logic [1:0]  err_clr_bits,
    input logic [31:0] rd_data,
    input logic [3:0]  lvl_bits,
    input logic [1:0]  err_bits,
    input logic [19:0] word_count,
    input logic [19:0] fifo_size
);
    // lvl_bits = status[15:12], err_bits = status[23:22]

    p_bounded_r3: assert property (@(posedge clk) disable iff (!rst_n)
        word_count <= fifo_size);

    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_clr |=> (word_count <= $past(word_count) + 20'd1) &&
                      ($past(word_count) <= word_count + 20'd1));

    p_rx_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_en && !rd_req && !fifo_clr) |=> $stable(word_count));

    p_over_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && rx_en && !fifo_clr && !lvl_bits[3] && !rd_req) |=> err_bits[1]);

    p_under_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !lvl_bits[0] && !fifo_clr) |=> err_bits[0]);

    p_empty_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !lvl_bits[0] |-> rd_data == 32'h0);

    p_over_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (err_bits[1] && !(err_clr_we && err_clr_bits[1])) |=> err_bits[1]);

    p_under_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (err_bits[0] && !(err_clr_we && err_clr_bits[0])) |=> err_bits[0]);

    p_clr_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_clr |=> word_count == 20'd0);

    p_empty_is_ae_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !lvl_bits[0] |-> !lvl_bits[1]);

    p_full_is_af_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !lvl_bits[3] |-> !lvl_bits[2]);
endmodule

bind rxcap_fifo rxcap_fifo_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fifo_clr     (fifo_clr),
    .rx_en        (rx_en),
    .wr_valid     (wr_valid),
    .rd_req       (rd_req),
    .err_clr_we   (err_clr_we),
    .err_clr_bits (err_clr_data[23:22]),
    .rd_data      (rd_data),
    .lvl_bits     (status[15:12]),
    .err_bits     (status[23:22]),
    .word_count   (word_count),
    .fifo_size    (fifo_size)
);

// File: tb/rxcap_fifo_test.sv
`timescale 1ns/1ps
// Self-checking bench for rxcap_fifo in an 8-word configuration.
module rxcap_fifo_test;
    localparam int AW  = 3;
    localparam int DEP = 1 << AW;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fifo_clr = 1'b0;
    logic        rx_en = 1'b0;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_req = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        err_clr_we = 1'b0;
    logic [31:0] err_clr_data = '0;
    logic [31:0] rd_data;
    logic [31:0] status;
    logic [19:0] word_count;
    logic [19:0] fifo_size;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [31:0] q[$];
    int m_ae = 32;
    int m_af = 32;
    bit m_ovr = 1'b0;
    bit m_und = 1'b0;
    bit m_rx  = 1'b0;

    always #2 clk = ~clk;

    rxcap_fifo #(.DATA_W(32), .DEPTH_LOG2(AW)) uut (
        .clk(clk), .rst_n(rst_n), .fifo_clr(fifo_clr), .rx_en(rx_en),
        .wr_valid(wr_valid), .wr_data(wr_data), .rd_req(rd_req),
        .rd_data(rd_data), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .err_clr_we(err_clr_we), .err_clr_data(err_clr_data),
        .status(status), .word_count(word_count), .fifo_size(fifo_size)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_status();
        int n = q.size();
        logic [31:0] s = '0;
        s[12] = (n != 0);
        s[13] = !(n <= m_ae);
        s[14] = !((DEP - n) <= m_af);
        s[15] = (n != DEP);
        s[22] = m_und;
        s[23] = m_ovr;
        return s;
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic set_rx(bit v);
        rx_en = v;
        m_rx  = v;
    endtask

    // One cycle of traffic; model follows R2, R4, R5, R6, R12.
    task automatic cyc(bit wv, logic [31:0] d, bit rr);
        bit pop;
        bit push;
        wr_valid = wv;
        wr_data  = d;
        rd_req   = rr;
        if (rr) chk("R2/R6 rd_data", rd_data, (q.size() > 0) ? q[0] : 32'h0);
        tick();
        wr_valid = 1'b0;
        rd_req   = 1'b0;
        pop  = rr && (q.size() > 0);
        push = wv && m_rx && ((q.size() < DEP) || pop);
        if (wv && m_rx && (q.size() == DEP) && !pop) m_ovr = 1'b1;
        if (rr && (q.size() == 0)) m_und = 1'b1;
        if (pop) void'(q.pop_front());
        if (push) q.push_back(d);
    endtask

    task automatic state(string tag);
        chk({tag, " count"}, 32'(word_count), 32'(q.size()));
        chk({tag, " status"}, status, exp_status());
    endtask

    task automatic load_cfg(int ae, int af, logic [7:0] junk);
        cfg_wdata = {junk, 8'(af), 16'(ae)};
        cfg_we = 1'b1;
        tick();
        cfg_we = 1'b0;
        m_ae = ae;
        m_af = af;
    endtask

    task automatic clear_fifo();
        fifo_clr = 1'b1;
        tick();
        fifo_clr = 1'b0;
        q.delete();
    endtask

    task automatic err_clear(logic [31:0] mask);
        err_clr_data = mask;
        err_clr_we = 1'b1;
        tick();
        err_clr_we = 1'b0;
        err_clr_data = '0;
        if (mask[23]) m_ovr = 1'b0;
        if (mask[22]) m_und = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R1..: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state, R13 capacity and unused bits
        state("R1 reset");
        chk("R13 fifo_size", 32'(fifo_size), 32'(DEP));
        chk("R6 empty rd_data", rd_data, 32'h0);
        chk("R13 unused status bits", status & ~32'h00C0_F000, 32'h0);

        // R2 order over distinct patterns, R3 count tracking
        set_rx(1'b1);
        cyc(1'b1, 32'hA5A5_5A5A, 1'b0); state("R3 one");
        cyc(1'b1, 32'hFFFF_FFFF, 1'b0); state("R3 two");
        cyc(1'b1, 32'h0000_0000, 1'b0);
        cyc(1'b1, 32'h1234_5678, 1'b0);
        cyc(1'b1, 32'h8000_0001, 1'b0); state("R3 five");
        chk("R2 head", rd_data, 32'hA5A5_5A5A);
        for (int i = 0; i < 5; i++) begin
            cyc(1'b0, 32'h0, 1'b1);
            state("R2 drain");
        end

        // R3 fill to full, R5 overrun drops word, R12 read+write at full
        for (int i = 0; i < DEP; i++) cyc(1'b1, 32'h1111_1111 * (i + 1), 1'b0);
        state("R3 full");
        cyc(1'b1, 32'hDEAD_0001, 1'b0);
        state("R5 overrun");
        chk("R5 flag", 32'(status[23]), 32'd1);
        cyc(1'b1, 32'hCAFE_0002, 1'b1);
        state("R12 pass-through");
        for (int i = 0; i < DEP; i++) cyc(1'b0, 32'h0, 1'b1);
        state("R2 drained");

        // R6 underrun
        cyc(1'b0, 32'h0, 1'b1);
        state("R6 underrun");
        chk("R6 flag", 32'(status[22]), 32'd1);

        // R7 write-ones-to-clear
        err_clear(32'h0000_0000);
        state("R7 zero mask");
        err_clear(32'h0040_0000);
        state("R7 clear under only");
        chk("R7 over kept", 32'(status[23]), 32'd1);
        rd_req = 1'b1;
        err_clr_data = 32'h0040_0000;
        err_clr_we = 1'b1;
        tick();
        rd_req = 1'b0;
        err_clr_we = 1'b0;
        err_clr_data = '0;
        m_und = 1'b1;
        state("R7 set wins");
        err_clear(32'hFFFF_FFFF);
        state("R7 clear both");

        // R4 receive disabled
        set_rx(1'b0);
        for (int i = 0; i < 3; i++) cyc(1'b1, 32'h5555_0000 + i, 1'b0);
        state("R4 ignored empty");
        set_rx(1'b1);
        for (int i = 0; i < DEP; i++) cyc(1'b1, 32'h2000 + i, 1'b0);
        set_rx(1'b0);
        cyc(1'b1, 32'h6666_6666, 1'b0);
        state("R4 no overrun");
        set_rx(1'b1);

        // R8 FIFO clear keeps errors and drops same-cycle traffic
        cyc(1'b1, 32'h7777_0000, 1'b0);
        cyc(1'b0, 32'h0, 1'b1);
        cyc(1'b0, 32'h0, 1'b1);
        err_clear(32'h0);
        fifo_clr = 1'b1;
        wr_valid = 1'b1;
        wr_data  = 32'h9999_9999;
        rd_req   = 1'b1;
        tick();
        fifo_clr = 1'b0;
        wr_valid = 1'b0;
        rd_req   = 1'b0;
        q.delete();
        state("R8 cleared");
        chk("R8 over kept", 32'(status[23]), 32'd1);
        cyc(1'b1, 32'h0000_0077, 1'b0);
        cyc(1'b0, 32'h0, 1'b1);
        state("R8 reuse");
        err_clear(32'h00C0_0000);

        // R9, R10, R11 threshold sweep with ignored upper bits
        for (int ae = 0; ae < DEP + 2; ae++) begin
            for (int af = 0; af < DEP + 2; af++) begin
                load_cfg(ae, af, 8'hA5);
                clear_fifo();
                for (int k = 0; k <= DEP; k++) begin
                    state("R9/R10/R11 sweep");
                    if (k < DEP) cyc(1'b1, 32'(k), 1'b0);
                end
            end
        end

        // R9 upper almost-empty bits are honoured
        load_cfg(16'h0100, 0, 8'h00);
        clear_fifo();
        for (int k = 0; k < DEP; k++) cyc(1'b1, 32'(k), 1'b0);
        state("R10 wide threshold");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule